// File: doc/BRIEF.md
# Packet Clock-Crossing FIFO with Stall

This block carries fixed-width packets from a producer clock domain to a consumer clock domain. The producer raises a write enable together with a packet. Two level flags tell it how close the storage is to capacity. The consumer side turns stored packets into an access strobe with packet data. A wait input lets the downstream logic freeze a presented packet until it is ready to take it.

Pointers are Gray-coded and carry one extra wrap bit. Each pointer crosses into the opposite domain through a two-flop synchronizer that sits inside the block. One active-low asynchronous reset clears both sides, so the block still comes out of reset cleanly when one of the clocks is stopped.

The main full indication fires early, at a parameter-set distance below capacity. This gives the producer slack to absorb its own pipeline latency. The flag does not block writes. Only genuinely full storage refuses a packet.

Top module: `pkt_cdc_fifo`

## Requirements
- R1: Packets leave the read side unaltered (all PKT_W bits) and in the order they were accepted on the write side; no packet is presented twice and none appears that was never accepted.
- R2: A packet that has been taken from storage is presented on `rd_pkt` with `rd_access` high starting at the read-clock edge that takes it, which is one edge after the read decision.
- R3: At every read-clock edge where `rd_wait` is high, `rd_access` and `rd_pkt` keep the values they had before that edge.
- R4: No stored packet is consumed at a read-clock edge where `rd_wait` is high, so the packet following a stall is the next one in write order.
- R5: At a read-clock edge with `rd_wait` low and nothing stored, `rd_access` goes low and `rd_pkt` keeps its last value.
- R6: `full` is high exactly when the occupancy seen in the write domain is at least DEPTH − SLACK (DEPTH = 2^ADDR_W).
- R7: `almost_full` is high exactly when the occupancy seen in the write domain is at least DEPTH − 1; it never rises without `full` also being high.
- R8: A write is accepted while `full` is high as long as fewer than DEPTH packets are stored; a write made while DEPTH packets are stored is dropped.
- R9: Driving `arst_n` low clears `rd_access`, `rd_pkt`, `full` and `almost_full` at once, without any clock edge, and empties the storage on both sides.
- R10: A packet written into an empty, idle block is presented after no fewer than 2 and no more than 4 read-clock rising edges following its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request for `wr_pkt` this cycle |
| wr_pkt | input | PKT_W | Packet to store |
| full | output | 1 | Occupancy has reached DEPTH − SLACK (does not block writes) |
| almost_full | output | 1 | Occupancy has reached DEPTH − 1 |
| rd_clk | input | 1 | Read-domain clock |
| rd_wait | input | 1 | Stall: freeze the presented packet and consume nothing |
| rd_access | output | 1 | A packet is being presented on `rd_pkt` |
| rd_pkt | output | PKT_W | Presented packet, held when nothing new is taken |

## Verification
The bench builds the block with the default 104-bit packet, ADDR_W = 3 and SLACK = 3. This gives eight entries, with `full` at five and `almost_full` at seven. That small depth lets a short fill with the consumer stalled step through every flag threshold and then past true capacity, where writes are dropped. The random phase wraps the pointers many times under random stalls. The read clock runs at 14 ns against the 10 ns write clock, so edge alignment between the domains keeps shifting.

// File: rtl/pkt_cdc_fifo.sv
module pkt_cdc_fifo #(
  parameter int PKT_W  = 104,
  parameter int ADDR_W = 4,
  parameter int SLACK  = 4
) (
  input  logic             arst_n,
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [PKT_W-1:0] wr_pkt,
  output logic             full,
  output logic             almost_full,
  input  logic             rd_clk,
  input  logic             rd_wait,
  output logic             rd_access,
  output logic [PKT_W-1:0] rd_pkt
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam logic [PW-1:0] PFULL_LVL = PW'(DEPTH - SLACK);
  localparam logic [PW-1:0] AFULL_LVL = PW'(DEPTH - 1);
  localparam logic [PW-1:0] CAP       = PW'(DEPTH);

  logic [PKT_W-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nx;
  logic [PW-1:0] rbin, rgray, rbin_nx;
  logic [PW-1:0] wq1_rgray, wq2_rgray, rq1_wgray, rq2_wgray;
  logic [PW-1:0] rbin_seen, wocc;
  logic mem_full, empty, push, pop;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  assign mem_full = (wgray == {~wq2_rgray[PW-1:PW-2], wq2_rgray[PW-3:0]});
  assign push     = wr_en && !mem_full;
  assign wbin_nx  = wbin + PW'(push);

  always_ff @(posedge wr_clk or negedge arst_n)
    if (!arst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end

  always_ff @(posedge wr_clk)
    if (push) mem[wbin[ADDR_W-1:0]] <= wr_pkt;

  always_ff @(posedge wr_clk or negedge arst_n)
    if (!arst_n) {wq2_rgray, wq1_rgray} <= '0;
    else         {wq2_rgray, wq1_rgray} <= {wq1_rgray, rgray};

  assign rbin_seen   = gray2bin(wq2_rgray);
  assign wocc        = wbin - rbin_seen;
  assign full        = (wocc >= PFULL_LVL);
  assign almost_full = (wocc >= AFULL_LVL);

  // read domain
  always_ff @(posedge rd_clk or negedge arst_n)
    if (!arst_n) {rq2_wgray, rq1_wgray} <= '0;
    else         {rq2_wgray, rq1_wgray} <= {rq1_wgray, wgray};

  assign empty   = (rq2_wgray == rgray);
  assign pop     = !empty && !rd_wait;
  assign rbin_nx = rbin + PW'(pop);

  always_ff @(posedge rd_clk or negedge arst_n)
    if (!arst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      rd_access <= 1'b0;
      rd_pkt    <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      if (!rd_wait) rd_access <= pop;
      if (pop)      rd_pkt    <= mem[rbin[ADDR_W-1:0]];
    end

  AST_WAIT_FREEZES_OUT: assert property (@(posedge rd_clk) disable iff (!arst_n)
    rd_wait |=> ($stable(rd_pkt) && $stable(rd_access))); // R3
  AST_WAIT_HOLDS_PTR: assert property (@(posedge rd_clk) disable iff (!arst_n)
    rd_wait |=> $stable(rgray)); // R4
  AST_IDLE_DROPS_ACCESS: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (empty && !rd_wait) |=> (!rd_access && $stable(rd_pkt))); // R5
  AST_FLAG_NESTING: assert property (@(posedge wr_clk) disable iff (!arst_n)
    almost_full |-> full); // R7
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!arst_n)
    wocc <= CAP); // R8
endmodule

// File: tb/tb_pkt_cdc_fifo.sv
`timescale 1ns/100ps
module tb_pkt_cdc_fifo;
  localparam int PKT_W  = 104;
  localparam int ADDR_W = 3;
  localparam int SLACK  = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic arst_n, wr_clk, rd_clk, wr_en, rd_wait;
  logic [PKT_W-1:0] wr_pkt;
  logic full, almost_full, rd_access;
  logic [PKT_W-1:0] rd_pkt;

  pkt_cdc_fifo #(.PKT_W(PKT_W), .ADDR_W(ADDR_W), .SLACK(SLACK)) dut (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_pkt(wr_pkt),
    .full(full), .almost_full(almost_full), .rd_clk(rd_clk),
    .rd_wait(rd_wait), .rd_access(rd_access), .rd_pkt(rd_pkt));

  int tests = 0, fails = 0, delivered = 0, seq = 0;
  logic [PKT_W-1:0] mq[$];
  logic mon_on = 0, armed = 0, w_edge = 0, prev_acc = 0;
  logic [PKT_W-1:0] prev_pkt = '0;

  initial wr_clk = 0;
  always #5 wr_clk = ~wr_clk;
  initial rd_clk = 0;
  always #7 rd_clk = ~rd_clk;

  task automatic check(input string req, input logic [PKT_W-1:0] act, input logic [PKT_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [PKT_W-1:0] mkpkt(input int s);
    logic [31:0] u;
    u = $urandom;
    return {s[31:0], ~s[31:0], u, s[7:0]};
  endfunction

  // write-side model
  always @(posedge wr_clk)
    if (arst_n && wr_en && mq.size() < DEPTH) mq.push_back(wr_pkt);

  always @(posedge rd_clk) w_edge <= rd_wait;

  // read-side reference compared on every read clock
  always @(negedge rd_clk) begin
    if (mon_on && armed) begin
      if (w_edge) begin
        check("R3 access hold", rd_access, prev_acc);
        check("R3 packet hold", rd_pkt, prev_pkt);
      end else if (rd_access) begin
        if (mq.size() == 0) check("R1 spurious packet", 1'b1, 1'b0);
        else begin
          check("R1/R4 packet order", rd_pkt, mq.pop_front());
          delivered++;
        end
      end else begin
        check("R5 idle packet held", rd_pkt, prev_pkt);
      end
    end
    prev_acc = rd_access;
    prev_pkt = rd_pkt;
    armed    = mon_on;
  end

  task automatic write_one(input logic [PKT_W-1:0] p);
    @(negedge wr_clk);
    wr_en = 1; wr_pkt = p;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic rd_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k, d0;
    arst_n = 1; wr_en = 0; wr_pkt = '0; rd_wait = 0;
    #2 arst_n = 0;
    #1;
    check("R9 reset access", rd_access, 1'b0);
    check("R9 reset packet", rd_pkt, '0);
    check("R9 reset full", full, 1'b0);
    check("R9 reset almost_full", almost_full, 1'b0);
    #40 arst_n = 1;
    mon_on = 1;
    rd_cycles(3);

    // R10 / R2: single packet latency
    @(negedge wr_clk);
    wr_en = 1; wr_pkt = mkpkt(seq++);
    @(posedge wr_clk);
    k = 0;
    while (k < 8) begin
      @(posedge rd_clk); k++;
      @(negedge rd_clk);
      if (rd_access) break;
    end
    wr_en = 0;
    check("R10 first presentation", 1'(k >= 2 && k <= 4), 1'b1);
    check("R2 access after take", rd_access, 1'b1);
    rd_cycles(4);

    // R6/R7/R8: fill with consumer stalled
    @(negedge rd_clk) rd_wait = 1;
    rd_cycles(4);
    d0 = delivered;
    for (int i = 0; i < DEPTH + 3; i++) begin
      int n;
      write_one(mkpkt(seq++));
      n = (i + 1 < DEPTH) ? i + 1 : DEPTH;
      check("R6 full level", full, 1'(n >= DEPTH - SLACK));
      check("R7 almost_full level", almost_full, 1'(n >= DEPTH - 1));
    end
    @(negedge rd_clk) rd_wait = 0;
    rd_cycles(40);
    check("R8 stored count", PKT_W'(delivered - d0), PKT_W'(DEPTH));
    check("R1 queue drained", PKT_W'(mq.size()), '0);
    check("R6 full clears", full, 1'b0);
    check("R7 almost_full clears", almost_full, 1'b0);

    // random traffic with random stalls
    fork
      for (int i = 0; i < 600; i++) begin
        @(negedge wr_clk);
        if (!full && ($urandom % 3 != 0)) begin
          wr_en = 1; wr_pkt = mkpkt(seq++);
        end else wr_en = 0;
      end
      for (int i = 0; i < 420; i++) begin
        @(negedge rd_clk);
        rd_wait = ($urandom % 4 == 0);
      end
    join
    @(negedge wr_clk) wr_en = 0;
    @(negedge rd_clk) rd_wait = 0;
    rd_cycles(40);
    check("R1 random traffic drained", PKT_W'(mq.size()), '0);

    // R9: asynchronous reset with a stalled packet and full flag
    write_one(mkpkt(seq++));
    k = 0;
    while (k < 10 && !rd_access) begin @(negedge rd_clk); k++; end
    rd_wait = 1;
    for (int i = 0; i < 5; i++) write_one(mkpkt(seq++));
    repeat (4) @(negedge wr_clk);
    check("R6 full with five waiting", full, 1'b1);
    check("R3 access held under wait", rd_access, 1'b1);
    mon_on = 0;
    #3 arst_n = 0;
    #1;
    check("R9 async access", rd_access, 1'b0);
    check("R9 async packet", rd_pkt, '0);
    check("R9 async full", full, 1'b0);
    check("R9 async almost_full", almost_full, 1'b0);
    mq.delete();
    #30 arst_n = 1;
    @(negedge rd_clk) rd_wait = 0;
    mon_on = 1;
    rd_cycles(12);
    check("R9 nothing left after reset", rd_access, 1'b0);
    check("R9 flags after reset", {full, almost_full}, '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule